// File: doc/BRIEF.md
# Register File with Delayed Load Write-Back

This block is the general-purpose register store of an in-order RISC core whose loads expose a one-instruction delay slot. Two read ports serve operand fetch and one write port takes ALU results at once. Load results take a separate path: they are parked in a two-entry delay pipeline and reach the array only when the instruction after the load finishes. The core pulses a retire strobe once per finished instruction, and that strobe is the only thing that moves the delay pipeline.

A third read port, meant for partial-word load merging, sees the load that is still in flight. The normal read ports do not. A write from the delay-slot instruction to the register of the pending load beats that load, and so does a second load to the same register. A pair of multiply/divide result registers sits beside the array, each with its own direct write enable.

Top module: `gdb_top`

## Requirements
- R1: Register index 0 reads as 0 on every read port. A write to index 0 through the immediate port is discarded.
- R2: A load to index 0 is discarded. It does not cancel a pending load to another register.
- R3: An immediate write to a non-zero index is returned by the read ports from the next cycle on.
- R4: A load issued by an instruction that retires is not visible on the normal read ports during the following instruction (the delay slot). It becomes visible once that following instruction has retired.
- R5: If the delay-slot instruction writes the pending load's register through the immediate port, that register keeps the immediate value and the load never lands.
- R6: If two loads to the same register retire back to back, only the second value ever appears in the array.
- R7: While retire is low, the delay pipeline does not advance. A pending load stays off the array and stays visible on the bypass port.
- R8: The bypass read port returns the in-flight load data when its index equals the in-flight register and that register is non-zero. Otherwise it returns the array contents, and index 0 returns 0.
- R9: The HI and LO registers take their write data on the clock edge where their own enable is high, independently of each other. Their outputs show the new value in the next cycle.
- R10: Synchronous active-high reset clears all registers, HI, LO and both delay entries to 0.
- R11: Loads to two different registers retired back to back both commit, each one instruction after its own issue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| retire | input | 1 | The current instruction finishes at this edge |
| wr_en | input | 1 | Immediate write enable |
| wr_idx | input | 5 | Immediate write register |
| wr_data | input | 32 | Immediate write data |
| ld_en | input | 1 | Load result issue |
| ld_idx | input | 5 | Load destination register |
| ld_data | input | 32 | Load data |
| rd_a_idx | input | 5 | Read port A register |
| rd_a_data | output | 32 | Read port A data (array only) |
| rd_b_idx | input | 5 | Read port B register |
| rd_b_data | output | 32 | Read port B data (array only) |
| byp_idx | input | 5 | Bypass read register |
| byp_data | output | 32 | Bypass read data (in-flight load first) |
| hi_we | input | 1 | HI write enable |
| hi_wdata | input | 32 | HI write data |
| hi_q | output | 32 | HI contents |
| lo_we | input | 1 | LO write enable |
| lo_wdata | input | 32 | LO write data |
| lo_q | output | 32 | LO contents |

## Verification
All reads are combinational from registered state. An immediate write or a HI/LO write therefore shows one cycle after its edge. A load shows on the bypass port one retired instruction after issue, and on the normal ports two retired instructions after issue. Non-retiring cycles add no progress. The bench models the array and the delay pair itself. It drives each instruction on the falling edge and records the expected outputs from the model's state before the coming edge. A monitor compares those outputs a nanosecond later, so each read is checked in the same cycle it is presented, against state settled at the previous rising edge.

// File: rtl/gdb_pkg.sv
package gdb_pkg;
  localparam int unsigned XLEN = 32;
  localparam int unsigned NREG = 32;
  localparam int unsigned IDXW = $clog2(NREG);

  typedef struct packed {
    logic [IDXW-1:0] idx;
    logic [XLEN-1:0] data;
  } slot_t;

  localparam slot_t SLOT_CLR = '{idx: '0, data: '0};

  // true when idx names a real (non-zero) register and equals ref_idx
  function automatic logic fn_hit(input logic [IDXW-1:0] idx,
                                  input logic [IDXW-1:0] ref_idx);
    return (idx != '0) && (idx == ref_idx);
  endfunction

  // bypass selection: in-flight load beats the array on a hit
  function automatic logic [XLEN-1:0] fn_pick(input logic hit,
                                              input logic [XLEN-1:0] flight,
                                              input logic [XLEN-1:0] arr);
    return hit ? flight : arr;
  endfunction
endpackage

// File: rtl/gdb_array.sv
module gdb_array
  import gdb_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            imm_en,
  input  logic [IDXW-1:0] imm_idx,
  input  logic [XLEN-1:0] imm_data,
  input  logic            cmt_en,
  input  logic [IDXW-1:0] cmt_idx,
  input  logic [XLEN-1:0] cmt_data,
  input  logic [IDXW-1:0] ra_idx,
  output logic [XLEN-1:0] ra_data,
  input  logic [IDXW-1:0] rb_idx,
  output logic [XLEN-1:0] rb_data,
  input  logic [IDXW-1:0] rc_idx,
  output logic [XLEN-1:0] rc_data
);
  logic [XLEN-1:0] mem [NREG];

  assign mem[0] = '0;

  for (genvar g = 1; g < NREG; g++) begin : g_reg
    logic [XLEN-1:0] q;
    logic            hit_imm;
    logic            hit_cmt;
    assign hit_imm = imm_en && (imm_idx == IDXW'(g));
    assign hit_cmt = cmt_en && (cmt_idx == IDXW'(g));
    always_ff @(posedge clk) begin
      if (rst)          q <= '0;
      else if (hit_imm) q <= imm_data;
      else if (hit_cmt) q <= cmt_data;
    end
    assign mem[g] = q;
  end

  assign ra_data = mem[ra_idx];
  assign rb_data = mem[rb_idx];
  assign rc_data = mem[rc_idx];

  // R3: immediate write lands and wins
  a_r3_imm_lands: assert property (@(posedge clk) disable iff (rst)
    (imm_en && imm_idx != '0) |=> mem[$past(imm_idx)] == $past(imm_data));

  // R4: delayed commit lands when no immediate write collides
  a_r4_commit_lands: assert property (@(posedge clk) disable iff (rst)
    (cmt_en && cmt_idx != '0 && !(imm_en && imm_idx == cmt_idx))
      |=> mem[$past(cmt_idx)] == $past(cmt_data));

  // R1: register zero reads zero
  a_r1_zero_a: assert property (@(posedge clk) disable iff (rst)
    (ra_idx == '0) |-> (ra_data == '0));
endmodule

// File: rtl/gdb_delay_pipe.sv
module gdb_delay_pipe
  import gdb_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            retire,
  input  logic            imm_en,
  input  logic [IDXW-1:0] imm_idx,
  input  logic            ld_en,
  input  logic [IDXW-1:0] ld_idx,
  input  logic [XLEN-1:0] ld_data,
  output logic [IDXW-1:0] infl_idx,
  output logic [XLEN-1:0] infl_data,
  output logic            cmt_en,
  output logic [IDXW-1:0] cmt_idx,
  output logic [XLEN-1:0] cmt_data,
  output logic            evt_cancel
);
  slot_t infl_q, nxt_q;
  slot_t infl_live, nxt_eff;
  logic  ld_take;

  assign ld_take    = ld_en && (ld_idx != '0);
  assign evt_cancel = (imm_en && fn_hit(imm_idx, infl_q.idx)) ||
                      (ld_take && fn_hit(ld_idx, infl_q.idx));

  always_comb begin
    infl_live = evt_cancel ? SLOT_CLR : infl_q;
    nxt_eff   = ld_take ? slot_t'{idx: ld_idx, data: ld_data} : nxt_q;
  end

  assign cmt_en   = retire && (infl_live.idx != '0);
  assign cmt_idx  = infl_live.idx;
  assign cmt_data = infl_live.data;

  always_ff @(posedge clk) begin
    if (rst) begin
      infl_q <= SLOT_CLR;
      nxt_q  <= SLOT_CLR;
    end else if (retire) begin
      infl_q <= nxt_eff;
      nxt_q  <= SLOT_CLR;
    end else begin
      infl_q <= infl_live;
      nxt_q  <= nxt_eff;
    end
  end

  assign infl_idx  = infl_q.idx;
  assign infl_data = infl_q.data;

  // R7: without retire or cancel, the in-flight entry holds
  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    (!retire && !evt_cancel) |=> ($stable(infl_idx) && $stable(infl_data)));

  // R4: a retire always drains the staging entry
  a_r4_drain: assert property (@(posedge clk) disable iff (rst)
    retire |=> (nxt_q.idx == '0));

  // R2: loads to register zero never become in flight
  a_r2_no_zero_load: assert property (@(posedge clk) disable iff (rst)
    (retire && ld_en && ld_idx == '0 && nxt_q.idx == '0) |=> (infl_idx == '0));
endmodule

// File: rtl/gdb_hilo.sv
module gdb_hilo
  import gdb_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            hi_we,
  input  logic [XLEN-1:0] hi_wdata,
  input  logic            lo_we,
  input  logic [XLEN-1:0] lo_wdata,
  output logic [XLEN-1:0] hi_q,
  output logic [XLEN-1:0] lo_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q <= '0;
      lo_q <= '0;
    end else begin
      if (hi_we) hi_q <= hi_wdata;
      if (lo_we) lo_q <= lo_wdata;
    end
  end

  // R9: each half takes its own data
  a_r9_hi: assert property (@(posedge clk) disable iff (rst)
    hi_we |=> hi_q == $past(hi_wdata));
  a_r9_lo_hold: assert property (@(posedge clk) disable iff (rst)
    !lo_we |=> $stable(lo_q));
endmodule

// File: rtl/gdb_top.sv
module gdb_top
  import gdb_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            retire,
  input  logic            wr_en,
  input  logic [IDXW-1:0] wr_idx,
  input  logic [XLEN-1:0] wr_data,
  input  logic            ld_en,
  input  logic [IDXW-1:0] ld_idx,
  input  logic [XLEN-1:0] ld_data,
  input  logic [IDXW-1:0] rd_a_idx,
  output logic [XLEN-1:0] rd_a_data,
  input  logic [IDXW-1:0] rd_b_idx,
  output logic [XLEN-1:0] rd_b_data,
  input  logic [IDXW-1:0] byp_idx,
  output logic [XLEN-1:0] byp_data,
  input  logic            hi_we,
  input  logic [XLEN-1:0] hi_wdata,
  output logic [XLEN-1:0] hi_q,
  input  logic            lo_we,
  input  logic [XLEN-1:0] lo_wdata,
  output logic [XLEN-1:0] lo_q
);
  logic [IDXW-1:0] infl_idx;
  logic [XLEN-1:0] infl_data;
  logic            cmt_en;
  logic [IDXW-1:0] cmt_idx;
  logic [XLEN-1:0] cmt_data;
  logic            evt_cancel;
  logic [XLEN-1:0] arr_c;
  logic            byp_hit;

  gdb_delay_pipe u_pipe (
    .clk(clk), .rst(rst), .retire(retire),
    .imm_en(wr_en), .imm_idx(wr_idx),
    .ld_en(ld_en), .ld_idx(ld_idx), .ld_data(ld_data),
    .infl_idx(infl_idx), .infl_data(infl_data),
    .cmt_en(cmt_en), .cmt_idx(cmt_idx), .cmt_data(cmt_data),
    .evt_cancel(evt_cancel)
  );

  gdb_array u_arr (
    .clk(clk), .rst(rst),
    .imm_en(wr_en), .imm_idx(wr_idx), .imm_data(wr_data),
    .cmt_en(cmt_en), .cmt_idx(cmt_idx), .cmt_data(cmt_data),
    .ra_idx(rd_a_idx), .ra_data(rd_a_data),
    .rb_idx(rd_b_idx), .rb_data(rd_b_data),
    .rc_idx(byp_idx), .rc_data(arr_c)
  );

  gdb_hilo u_hilo (
    .clk(clk), .rst(rst),
    .hi_we(hi_we), .hi_wdata(hi_wdata),
    .lo_we(lo_we), .lo_wdata(lo_wdata),
    .hi_q(hi_q), .lo_q(lo_q)
  );

  assign byp_hit  = fn_hit(byp_idx, infl_idx);
  assign byp_data = fn_pick(byp_hit, infl_data, arr_c);

  // R8: bypass of register zero is zero
  a_r8_byp_zero: assert property (@(posedge clk) disable iff (rst)
    (byp_idx == '0) |-> (byp_data == '0));

  // R5: a cancelling cycle never commits to the cancelled register
  a_r5_cancel_no_commit: assert property (@(posedge clk) disable iff (rst)
    (evt_cancel && wr_en) |-> !(cmt_en && cmt_idx == wr_idx));
endmodule

// File: tb/sim_gdb_top.sv
module sim_gdb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic retire = 0, wr_en = 0, ld_en = 0, hi_we = 0, lo_we = 0;
  logic [4:0]  wr_idx = 0, ld_idx = 0, rd_a_idx = 0, rd_b_idx = 0, byp_idx = 0;
  logic [31:0] wr_data = 0, ld_data = 0, hi_wdata = 0, lo_wdata = 0;
  logic [31:0] rd_a_data, rd_b_data, byp_data, hi_q, lo_q;

  always #2.5 clk = ~clk;

  gdb_top u0 (.*);

  typedef struct { logic [31:0] ea, eb, ec, eh, el; string tag; } item_t;
  item_t sbq[$];
  int total = 0, bad = 0;
  bit done = 0;

  // reference model
  logic [31:0] m_rf [32];
  logic [4:0]  m_fi, m_ni;
  logic [31:0] m_fd, m_nd, m_hi, m_lo;

  task automatic m_reset();
    for (int i = 0; i < 32; i++) m_rf[i] = 0;
    m_fi = 0; m_fd = 0; m_ni = 0; m_nd = 0; m_hi = 0; m_lo = 0;
  endtask

  task automatic m_edge();
    logic [4:0] ni; logic [31:0] nd; logic [4:0] fi; logic [31:0] fd;
    fi = m_fi; fd = m_fd;
    if ((wr_en && wr_idx != 0 && wr_idx == fi) || (ld_en && ld_idx != 0 && ld_idx == fi)) begin
      fi = 0; fd = 0;
    end
    ni = m_ni; nd = m_nd;
    if (ld_en && ld_idx != 0) begin ni = ld_idx; nd = ld_data; end
    if (wr_en && wr_idx != 0) m_rf[wr_idx] = wr_data;
    if (retire) begin
      if (fi != 0) m_rf[fi] = fd;
      m_fi = ni; m_fd = nd; m_ni = 0; m_nd = 0;
    end else begin
      m_fi = fi; m_fd = fd; m_ni = ni; m_nd = nd;
    end
    if (hi_we) m_hi = hi_wdata;
    if (lo_we) m_lo = lo_wdata;
  endtask

  task automatic idle();
    retire = 1; wr_en = 0; ld_en = 0; hi_we = 0; lo_we = 0;
  endtask

  // drive one cycle (controls already set by caller), expect reads from model
  task automatic issue(input logic [4:0] ra, input logic [4:0] rb,
                       input logic [4:0] bi, input string tag);
    item_t it;
    rd_a_idx = ra; rd_b_idx = rb; byp_idx = bi;
    it.ea = m_rf[ra]; it.eb = m_rf[rb];
    it.ec = (bi != 0 && bi == m_fi) ? m_fd : m_rf[bi];
    it.eh = m_hi; it.el = m_lo; it.tag = tag;
    sbq.push_back(it);
    m_edge();
    @(negedge clk);
  endtask

  task automatic op_wr(input logic [4:0] i, input logic [31:0] d) ;
    idle(); wr_en = 1; wr_idx = i; wr_data = d;
  endtask
  task automatic op_ld(input logic [4:0] i, input logic [31:0] d);
    idle(); ld_en = 1; ld_idx = i; ld_data = d;
  endtask

  task automatic cmp(input logic [31:0] act, input logic [31:0] exp,
                     input string tag, input string port);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, port, act, exp);
    end
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk); #1;
      if (sbq.size() > 0) begin
        item_t it;
        it = sbq.pop_front();
        cmp(rd_a_data, it.ea, it.tag, "rd_a");
        cmp(rd_b_data, it.eb, it.tag, "rd_b");
        cmp(byp_data,  it.ec, it.tag, "byp");
        cmp(hi_q,      it.eh, it.tag, "hi");
        cmp(lo_q,      it.el, it.tag, "lo");
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    m_reset();
    idle(); retire = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    // R10: reset state
    idle(); issue(5, 31, 7, "R10 reset");
    // R3: immediate writes
    op_wr(5, 32'h1111_1111); issue(5, 6, 5, "R3 before");
    op_wr(31, 32'h3131_3131); issue(5, 31, 5, "R3 visible");
    idle(); issue(31, 5, 31, "R3 visible2");
    // R1: write to r0 discarded
    op_wr(0, 32'hDEAD_BEEF); issue(0, 0, 0, "R1 wr0");
    idle(); issue(0, 5, 0, "R1 read0");
    // R4 and R8: load timing and bypass
    op_wr(7, 32'h0000_0077); issue(7, 7, 7, "R4 setup");
    op_ld(7, 32'hAAAA_0007); issue(7, 7, 7, "R4 issue");
    idle(); issue(7, 5, 7, "R4 slot old R8 byp");
    idle(); issue(7, 7, 7, "R4 landed");
    // R5: delay slot write wins
    op_ld(8, 32'h8888_0001); issue(8, 8, 8, "R5 issue");
    op_wr(8, 32'h8888_0002); issue(8, 8, 8, "R5 slot write");
    idle(); issue(8, 8, 8, "R5 wins");
    idle(); issue(8, 8, 8, "R5 wins2");
    // R6: back-to-back loads same register
    op_ld(9, 32'h9999_0001); issue(9, 9, 9, "R6 first");
    op_ld(9, 32'h9999_0002); issue(9, 9, 9, "R6 second");
    idle(); issue(9, 9, 9, "R6 slot");
    idle(); issue(9, 9, 9, "R6 later only");
    // R11: back-to-back loads different registers
    op_ld(10, 32'hA0A0_A0A0); issue(10, 11, 10, "R11 first");
    op_ld(11, 32'hB1B1_B1B1); issue(10, 11, 11, "R11 second");
    idle(); issue(10, 11, 11, "R11 slot");
    idle(); issue(10, 11, 10, "R11 both");
    // R7: stall without retire
    op_ld(12, 32'hCCCC_000C); issue(12, 12, 12, "R7 issue");
    idle(); retire = 0; issue(12, 12, 12, "R7 stall1");
    idle(); retire = 0; issue(12, 12, 12, "R7 stall2");
    idle(); issue(12, 12, 12, "R7 retire");
    idle(); issue(12, 12, 12, "R7 landed");
    // R2: load to r0 discarded and does not cancel
    op_ld(0, 32'h0BAD_0BAD); issue(0, 0, 0, "R2 ld0");
    idle(); issue(0, 0, 0, "R2 slot");
    op_ld(13, 32'hD0D0_D0D0); issue(13, 0, 13, "R2 pend");
    op_ld(0, 32'h1234_5678); issue(13, 0, 13, "R2 ld0 slot");
    idle(); issue(13, 0, 0, "R2 landed");
    // R8: bypass miss returns array
    op_ld(14, 32'hE0E0_E0E0); issue(14, 5, 5, "R8 issue");
    idle(); issue(14, 5, 5, "R8 miss");
    idle(); issue(14, 5, 14, "R8 array");
    // R9: HI/LO
    idle(); hi_we = 1; hi_wdata = 32'h4849_4849; issue(0, 0, 0, "R9 hi");
    idle(); lo_we = 1; lo_wdata = 32'h4C4F_4C4F; issue(0, 0, 0, "R9 lo");
    idle(); hi_we = 1; lo_we = 1; hi_wdata = 32'h1; lo_wdata = 32'h2; issue(0, 0, 0, "R9 both");
    idle(); issue(0, 0, 0, "R9 after");
    // R10: reset clears everything, including a pending load
    op_ld(15, 32'hFFFF_000F); issue(15, 5, 15, "R10 preload");
    idle(); rst = 1; m_reset(); @(negedge clk); rst = 0;
    idle(); issue(15, 5, 15, "R10 cleared");
    idle(); issue(15, 31, 15, "R10 cleared2");
    idle();
    repeat (3) @(negedge clk);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule